// File: doc/BRIEF.md
# Range Profile Group Decimator

This block shrinks the range profile of each chirp before Doppler processing. Complex range samples come in one per valid cycle. The block collects them into consecutive groups of `FACTOR` members and emits one complex value per group, together with the index of that group. With the default parameters, 1024 range samples become 64 output bins in groups of 16. The main reduction keeps the group member with the strongest response, estimated as |I|+|Q|, and passes its I and Q through untouched. Two other reductions are available: keep the first member of each group, or output the group mean.

A start-bin input chooses how many leading samples of a chirp are dropped before grouping begins. The reduction select and the start bin are both captured on the first valid sample of a chirp and hold for the rest of that chirp. Once the last group has been emitted, the block spends one cycle in an emit state and one in a done state, and then returns to idle. It ignores valid input during those two cycles. The next valid sample after that opens a new chirp, so chirps may follow one another with only short gaps.

Top module: `profile_decimator`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_i`, `out_q` and `out_bin` are 0.
- R2: Each chirp produces exactly `OUT_BINS` pulses of `out_valid`, with `out_bin` counting 0, 1, … `OUT_BINS-1`. Each pulse lasts one cycle and is seen in the cycle after the clock edge that accepts the group's last member.
- R3: With `mode_sel` = 2'b01, each output is the group member with the largest |I|+|Q|, with its I and Q unchanged. The value -32768 counts as magnitude 32768.
- R4: In the magnitude-pick reductions, when two or more members tie for the largest |I|+|Q|, the earliest of them in the group is output.
- R5: With `mode_sel` = 2'b00, each output is the first member of its group.
- R6: With `mode_sel` = 2'b10, the I and Q of each output are the sums over the group shifted arithmetically right by log2(`FACTOR`). This rounds toward minus infinity, so a group of all -1 gives -1 and a group of all -32768 gives -32768.
- R7: The first `start_bin` accepted samples of a chirp are discarded and count toward no group. With `start_bin` = 0, the first valid sample is member 0 of group 0.
- R8: After the cycle that shows bin `OUT_BINS-1`, the block ignores valid input for two clock edges (emit, then done). The valid sample after that starts a new chirp.
- R9: `mode_sel` and `start_bin` are sampled on the valid sample that starts a chirp. Changing them later in the same chirp has no effect on that chirp.
- R10: Cycles with `in_valid` low neither advance grouping nor change any output. Outside valid pulses, `out_i`, `out_q` and `out_bin` hold their last values.
- R11: `mode_sel` = 2'b11 behaves exactly like 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | In-phase input sample, signed |
| in_q | input | W | Quadrature input sample, signed |
| mode_sel | input | 2 | Reduction select: 00 first member, 01 magnitude pick, 10 mean, 11 magnitude pick |
| start_bin | input | log2(IN_BINS) | Number of leading samples dropped per chirp |
| out_valid | output | 1 | One-cycle pulse per reduced bin |
| out_i | output | W | Reduced in-phase value, signed |
| out_q | output | W | Reduced quadrature value, signed |
| out_bin | output | log2(OUT_BINS) | Index of the reduced bin |

## Verification
The bench goes after these corner cases:
- Magnitude ties, and full-scale negative samples. A design that uses `>=`, or lets two's complement overflow in its absolute value, would pick a later member or a near-zero sample instead of the true peak.
- Groups whose mean is negative. A logical shift, or a sum truncated before the shift, would give large positive values.
- A start bin of 15 and of 100, with a ramp input. An off-by-one in the skip counter would shift every output by one sample.
- Valid held high across the end of one chirp into the next. Without the two dead cycles, the second chirp would start two samples early and every bin of it would differ.
- Changing the reduction select and start bin in the middle of a chirp. An unlatched design would switch reduction part-way through.

// File: rtl/pd_pkg.sv
package pd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PROCESS = 2'd1,
      ST_EMIT    = 2'd2,
      ST_DONE    = 2'd3
   } pd_state_e;

   typedef enum logic [1:0] {
      RED_FIRST = 2'b00,
      RED_PEAK  = 2'b01,
      RED_MEAN  = 2'b10,
      RED_PEAK2 = 2'b11
   } pd_mode_e;

   function automatic int unsigned pd_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pd_absmag.sv
// |I| + |Q| magnitude estimate, one lane per component.
module pd_absmag #(
   parameter int W = 16
) (
   input  logic signed [W-1:0] smp_i,
   input  logic signed [W-1:0] smp_q,
   output logic        [W:0]   mag
);
   localparam int LANES = 2;

   logic signed [W-1:0] lane_v [LANES];
   logic        [W-1:0] lane_a [LANES];

   assign lane_v[0] = smp_i;
   assign lane_v[1] = smp_q;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      // -2^(W-1) negates to itself, which reads correctly as 2^(W-1) unsigned
      logic signed [W-1:0] neg_v;
      assign neg_v     = -lane_v[k];
      assign lane_a[k] = lane_v[k][W-1] ? neg_v : lane_v[k];
   end

   assign mag = {1'b0, lane_a[0]} + {1'b0, lane_a[1]};
endmodule

// File: rtl/pd_seq.sv
// Per-chirp sequencer: skip counter, group member and group index.
module pd_seq
   import pd_pkg::*;
#(
   parameter int IN_BINS  = 1024,
   parameter int OUT_BINS = 64,
   parameter int FACTOR   = 16,
   localparam int SBW = pd_width(IN_BINS),
   localparam int MBW = pd_width(FACTOR),
   localparam int GBW = pd_width(OUT_BINS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [1:0]     mode_in,
   input  logic [SBW-1:0] start_in,
   output logic           take,
   output logic           first,
   output logic           last,
   output logic [GBW-1:0] group,
   output pd_mode_e       mode_eff
);
   localparam logic [MBW-1:0] LAST_MEMBER = MBW'(FACTOR - 1);
   localparam logic [GBW-1:0] LAST_GROUP  = GBW'(OUT_BINS - 1);

   pd_state_e      state_q;
   logic [SBW-1:0] skip_q, start_q;
   logic [MBW-1:0] member_q;
   logic [GBW-1:0] group_q;
   pd_mode_e       mode_q;

   logic           idle, active, skipping, chirp_end;
   logic [SBW-1:0] skip_eff, start_eff;
   logic [MBW-1:0] member_eff;
   logic [GBW-1:0] group_eff;

   // In idle the counters read as zero and the live controls apply
   always_comb begin
      idle       = (state_q == ST_IDLE);
      active     = idle || (state_q == ST_PROCESS);
      skip_eff   = idle ? '0 : skip_q;
      start_eff  = idle ? start_in : start_q;
      member_eff = idle ? '0 : member_q;
      group_eff  = idle ? '0 : group_q;
      mode_eff   = idle ? pd_mode_e'(mode_in) : mode_q;
      skipping   = (skip_eff < start_eff);
      take       = in_valid && active && !skipping;
      first      = (member_eff == '0);
      last       = (member_eff == LAST_MEMBER);
      group      = group_eff;
      chirp_end  = take && last && (group_eff == LAST_GROUP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         skip_q   <= '0;
         start_q  <= '0;
         member_q <= '0;
         group_q  <= '0;
         mode_q   <= RED_FIRST;
      end else begin
         if (in_valid && active) begin
            skip_q   <= skipping ? skip_eff + 1'b1 : skip_eff;
            member_q <= !take ? member_eff : (last ? '0 : member_eff + 1'b1);
            group_q  <= (take && last) ? group_eff + 1'b1 : group_eff;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  start_q <= start_in;
                  mode_q  <= pd_mode_e'(mode_in);
                  state_q <= chirp_end ? ST_EMIT : ST_PROCESS;
               end
            end
            ST_PROCESS: if (chirp_end) state_q <= ST_EMIT;
            ST_EMIT:    state_q <= ST_DONE;
            ST_DONE:    state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pd_reduce.sv
// Group reduction datapath: running pick, running sum, result mux.
module pd_reduce
   import pd_pkg::*;
#(
   parameter int W      = 16,
   parameter int FACTOR = 16,
   localparam int LOG2F = $clog2(FACTOR),
   localparam int SUMW  = W + LOG2F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                first,
   input  pd_mode_e            mode,
   input  logic signed [W-1:0] in_i,
   input  logic signed [W-1:0] in_q,
   output logic signed [W-1:0] res_i,
   output logic signed [W-1:0] res_q
);
   logic        [W:0]   in_mag, held_mag;
   logic signed [W-1:0] held_i, held_q, pick_i, pick_q, mean_i, mean_q;
   logic                replace;

   pd_absmag #(.W(W)) u_mag (
      .smp_i (in_i),
      .smp_q (in_q),
      .mag   (in_mag)
   );

   // Strict compare keeps the earliest member on a tie
   always_comb begin
      if (mode == RED_FIRST) replace = first;
      else                   replace = first || (in_mag > held_mag);
      pick_i = replace ? in_i : held_i;
      pick_q = replace ? in_q : held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_i   <= '0;
         held_q   <= '0;
         held_mag <= '0;
      end else if (take && replace) begin
         held_i   <= in_i;
         held_q   <= in_q;
         held_mag <= in_mag;
      end
   end

   if (FACTOR == 1) begin : g_mean_pass
      assign mean_i = in_i;
      assign mean_q = in_q;
   end else begin : g_mean_acc
      logic signed [SUMW-1:0] ext_i, ext_q, sum_i, sum_q, nx_i, nx_q, sh_i, sh_q;
      assign ext_i = {{LOG2F{in_i[W-1]}}, in_i};
      assign ext_q = {{LOG2F{in_q[W-1]}}, in_q};
      assign nx_i  = first ? ext_i : sum_i + ext_i;
      assign nx_q  = first ? ext_q : sum_q + ext_q;
      assign sh_i  = nx_i >>> LOG2F;
      assign sh_q  = nx_q >>> LOG2F;
      assign mean_i = sh_i[W-1:0];
      assign mean_q = sh_q[W-1:0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_i <= '0;
            sum_q <= '0;
         end else if (take) begin
            sum_i <= nx_i;
            sum_q <= nx_q;
         end
      end
   end

   assign res_i = (mode == RED_MEAN) ? mean_i : pick_i;
   assign res_q = (mode == RED_MEAN) ? mean_q : pick_q;
endmodule

// File: rtl/profile_decimator.sv
module profile_decimator
   import pd_pkg::*;
#(
   parameter int W        = 16,
   parameter int IN_BINS  = 1024,
   parameter int OUT_BINS = 64,
   parameter int FACTOR   = 16,
   localparam int SBW = pd_width(IN_BINS),
   localparam int GBW = pd_width(OUT_BINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_i,
   input  logic signed [W-1:0] in_q,
   input  logic [1:0]          mode_sel,
   input  logic [SBW-1:0]      start_bin,
   output logic                out_valid,
   output logic signed [W-1:0] out_i,
   output logic signed [W-1:0] out_q,
   output logic [GBW-1:0]      out_bin
);
   if (IN_BINS != OUT_BINS * FACTOR) begin : g_bad_ratio
      $error("profile_decimator: IN_BINS must equal OUT_BINS * FACTOR");
   end
   if ((FACTOR & (FACTOR - 1)) != 0) begin : g_bad_factor
      $error("profile_decimator: FACTOR must be a power of two");
   end
   if (W < 2) begin : g_bad_width
      $error("profile_decimator: W must be at least 2");
   end

   logic                take, first, last;
   logic [GBW-1:0]      group;
   pd_mode_e            mode_eff;
   logic signed [W-1:0] res_i, res_q;

   pd_seq #(
      .IN_BINS  (IN_BINS),
      .OUT_BINS (OUT_BINS),
      .FACTOR   (FACTOR)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .mode_in  (mode_sel),
      .start_in (start_bin),
      .take     (take),
      .first    (first),
      .last     (last),
      .group    (group),
      .mode_eff (mode_eff)
   );

   pd_reduce #(
      .W      (W),
      .FACTOR (FACTOR)
   ) u_red (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .first (first),
      .mode  (mode_eff),
      .in_i  (in_i),
      .in_q  (in_q),
      .res_i (res_i),
      .res_q (res_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         out_bin   <= '0;
      end else begin
         out_valid <= take && last;
         if (take && last) begin
            out_i   <= res_i;
            out_q   <= res_q;
            out_bin <= group;
         end
      end
   end
endmodule

// File: rtl/profile_decimator_chk.sv
module pd_checker #(
   parameter int W        = 16,
   parameter int OUT_BINS = 64,
   parameter int FACTOR   = 16,
   parameter int GBW      = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                out_valid,
   input logic signed [W-1:0] out_i,
   input logic signed [W-1:0] out_q,
   input logic [GBW-1:0]      out_bin
);
   localparam logic [GBW-1:0] LAST_BIN = GBW'(OUT_BINS - 1);

   logic [GBW-1:0] want_bin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         want_bin <= '0;
      else if (out_valid) want_bin <= (want_bin == LAST_BIN) ? '0 : want_bin + 1'b1;
   end

   a_r2_bin_order: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_bin == want_bin);

   a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (FACTOR > 1) && out_valid |=> !out_valid);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_i) && $stable(out_q) && $stable(out_bin));

   a_r8_quiet_emit: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_bin == LAST_BIN |=> !out_valid);

   a_r8_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
      $past(out_valid && out_bin == LAST_BIN, 2) |-> !out_valid);
endmodule

bind profile_decimator pd_checker #(
   .W        (W),
   .OUT_BINS (OUT_BINS),
   .FACTOR   (FACTOR),
   .GBW      (GBW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q),
   .out_bin   (out_bin)
);

// File: tb/profile_decimator_bench.sv
module profile_decimator_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int IN_BINS    = 1024;
   localparam int OUT_BINS   = 64;
   localparam int FACTOR     = 16;
   localparam int SBW        = $clog2(IN_BINS);
   localparam int GBW        = $clog2(OUT_BINS);
   localparam int LOG2F      = $clog2(FACTOR);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] in_i = '0, in_q = '0;
   logic [1:0]          mode_sel = 2'b01;
   logic [SBW-1:0]      start_bin = '0;
   wire                 out_valid;
   wire signed [W-1:0]  out_i, out_q;
   wire [GBW-1:0]       out_bin;

   always #(CLK_PERIOD / 2) clk = ~clk;

   profile_decimator #(
      .W(W), .IN_BINS(IN_BINS), .OUT_BINS(OUT_BINS), .FACTOR(FACTOR)
   ) u_profile_decimator (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .mode_sel(mode_sel), .start_bin(start_bin), .out_valid(out_valid),
      .out_i(out_i), .out_q(out_q), .out_bin(out_bin)
   );

   int    checks = 0, failures = 0, seen = 0;
   string cur_req = "R1";
   bit    running = 0, finished = 0;

   // ---------------- behavioural reference ----------------
   int ph = 0, skip = 0, grp = 0, m_mode = 0, m_start = 0;
   int qi[$], qq[$];
   bit e_valid = 0;
   int e_i = 0, e_q = 0, e_bin = 0;

   task automatic model_reduce();
      int si = 0, sq = 0, best = -1, bi = 0;
      if (m_mode == 2) begin
         foreach (qi[j]) begin si += qi[j]; sq += qq[j]; end
         e_i = si >>> LOG2F;
         e_q = sq >>> LOG2F;
      end else if (m_mode == 0) begin
         e_i = qi[0]; e_q = qq[0];
      end else begin
         foreach (qi[j]) begin
            int mg = (qi[j] < 0 ? -qi[j] : qi[j]) + (qq[j] < 0 ? -qq[j] : qq[j]);
            if (mg > best) begin best = mg; bi = j; end
         end
         e_i = qi[bi]; e_q = qq[bi];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; e_valid = 0; e_i = 0; e_q = 0; e_bin = 0;
         qi.delete(); qq.delete();
      end else begin
         e_valid = 0;
         if (ph == 3) ph = 0;
         else if (ph == 2) ph = 3;
         else if (in_valid) begin
            if (ph == 0) begin
               m_mode = int'(mode_sel); m_start = int'(start_bin);
               skip = 0; grp = 0; qi.delete(); qq.delete(); ph = 1;
            end
            if (skip < m_start) skip++;
            else begin
               qi.push_back(int'(in_i)); qq.push_back(int'(in_q));
               if (qi.size() == FACTOR) begin
                  model_reduce();
                  e_valid = 1; e_bin = grp; grp++;
                  qi.delete(); qq.delete();
                  if (grp == OUT_BINS) ph = 2;
               end
            end
         end
      end
   end

   // ---------------- comparison every cycle ----------------
   always @(negedge clk) begin
      if (running && rst_n) begin
         checks++;
         if (out_valid) seen++;
         if (out_valid !== e_valid || int'(out_i) != e_i || int'(out_q) != e_q ||
             int'(out_bin) != e_bin) begin
            failures++;
            $display("FAIL %s t=%0t actual v=%0d i=%0d q=%0d bin=%0d expected v=%0d i=%0d q=%0d bin=%0d",
                     cur_req, $time, out_valid, out_i, out_q, out_bin,
                     e_valid, e_i, e_q, e_bin);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic int rnd16();
      return int'($urandom_range(0, 65535)) - 32768;
   endfunction

   task automatic put(input bit v, input int i, input int q);
      @(negedge clk);
      in_valid = v;
      in_i = W'(i);
      in_q = W'(q);
   endtask

   task automatic idle_gap(input int n);
      for (int k = 0; k < n; k++) put(0, 0, 0);
   endtask

   task automatic count_check(input int want, input string req);
      idle_gap(6);
      checks++;
      if (seen != want) begin
         failures++;
         $display("FAIL %s output count actual %0d expected %0d", req, seen, want);
      end
      seen = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      void'($urandom(17));
      // R1: reset values
      repeat (4) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0 || out_bin !== '0) begin
         failures++;
         $display("FAIL R1 reset actual v=%0d i=%0d q=%0d bin=%0d expected 0 0 0 0",
                  out_valid, out_i, out_q, out_bin);
      end
      rst_n = 1'b1;
      running = 1;
      idle_gap(3);

      // R3 R2: peak pick, full-scale negative group, peak on last member
      cur_req = "R3 R2"; mode_sel = 2'b01; start_bin = '0;
      for (int n = 0; n < IN_BINS; n++) begin
         int g = n / FACTOR, j = n % FACTOR;
         if (g == 0)      put(1, j == 7 ? -32768 : j, j == 7 ? -32768 : -j);
         else if (g == 1) put(1, j == 15 ? 32767 : 100, j == 15 ? 32767 : -100);
         else             put(1, rnd16(), rnd16());
      end
      count_check(OUT_BINS, "R2");

      // R4: equal magnitudes
      cur_req = "R4";
      for (int n = 0; n < IN_BINS; n++) begin
         int g = n / FACTOR, j = n % FACTOR;
         if (g % 2 == 0) begin
            int a = (j * 37) % 1000;
            put(1, (j & 1) ? -a : a, (j & 2) ? -(1000 - a) : 1000 - a);
         end else begin
            int mg = (j == 3 || j == 9) ? 900 : 10 + j;
            put(1, (j & 1) ? -(mg / 2) : mg / 2, mg - mg / 2);
         end
      end
      count_check(OUT_BINS, "R4");

      // R5 R10: first member with gaps in valid
      cur_req = "R5 R10"; mode_sel = 2'b00;
      for (int n = 0; n < IN_BINS; ) begin
         if ($urandom_range(0, 2) != 0) begin put(1, rnd16(), rnd16()); n++; end
         else put(0, rnd16(), rnd16());
      end
      count_check(OUT_BINS, "R5");

      // R6: mean with negative groups
      cur_req = "R6"; mode_sel = 2'b10;
      for (int n = 0; n < IN_BINS; n++) begin
         int g = n / FACTOR;
         if (g == 0)      put(1, -32768, -32768);
         else if (g == 1) put(1, -1, (n % FACTOR == 0) ? 0 : -1);
         else if (g == 2) put(1, 32767, -32767);
         else             put(1, rnd16(), rnd16());
      end
      count_check(OUT_BINS, "R6");

      // R7: start bin 15 on a ramp, first-member reduction
      cur_req = "R7"; mode_sel = 2'b00; start_bin = SBW'(15);
      for (int n = 0; n < IN_BINS + 15; n++) put(1, n, -n);
      count_check(OUT_BINS, "R7");

      // R7: start bin 100, peak pick
      cur_req = "R7 R3"; mode_sel = 2'b01; start_bin = SBW'(100);
      for (int n = 0; n < IN_BINS + 100; n++) put(1, rnd16(), rnd16());
      count_check(OUT_BINS, "R7");

      // R9: controls changed mid-chirp
      cur_req = "R9"; mode_sel = 2'b10; start_bin = '0;
      for (int n = 0; n < IN_BINS; n++) begin
         if (n == 200) begin mode_sel = 2'b00; start_bin = SBW'(7); end
         put(1, rnd16(), rnd16());
      end
      count_check(OUT_BINS, "R9");

      // R8: valid held high across the chirp boundary
      cur_req = "R8"; mode_sel = 2'b00; start_bin = '0;
      for (int n = 0; n < 2 * IN_BINS + 2; n++) put(1, n * 3, 5 - n);
      count_check(2 * OUT_BINS, "R8");

      // R11: mode 11 acts as peak pick
      cur_req = "R11"; mode_sel = 2'b11;
      for (int n = 0; n < IN_BINS; n++) put(1, rnd16(), rnd16());
      count_check(OUT_BINS, "R11");

      running = 0;
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL %s watchdog expired actual running expected finished", cur_req);
         summary();
         $finish;
      end
   end
endmodule